// File: doc/BRIEF.md
# Accumulator Processor Core with Time-Slot Sequencer

This block is a small processor core built around one 16-bit accumulator and a 4096-word internal memory. Each instruction runs as a series of numbered time slots. A sequence counter drives a decoder, and the decoder output enables the register transfers for each slot. All data moves over one shared 16-bit bus, and a numbered source select picks which register or the memory drives it. Every instruction fetches its word, decodes it and may resolve an indirect address. It then runs its execute slots, and the last of these resets the counter so that the next fetch follows at once.

The instruction word packs three fields. The upper bit is the indirect flag, the next three bits are the opcode and the low twelve bits are an address. Seven opcodes reference memory: logical AND, add with carry into a one-bit E flag, load, store, unconditional branch, branch-and-save-return-address, and increment-and-skip-if-zero. The eighth opcode is an extended class. Its indirect bit picks either register operations or input/output operations. I/O operations complete without touching any state. A halt operation freezes the core until reset. Software does subtraction by complementing and incrementing the accumulator, then adding.

A test environment loads the program image through a preload write port while `run_i` is low. It then raises `run_i` and reads results through the accumulator, program counter, carry, halt and memory peek ports.

Top module: `acc_cpu_core`

## Requirements
- R1: After reset, PC, AC and E are 0 and the halt flag is clear. While `run_i` is low, the sequencer does not advance, so PC stays at 0.
- R2: Each instruction starts at address PC with three fetch slots, and PC advances by one during fetch. Word bits 14:12 are the opcode: 0=AND, 1=ADD, 2=LDA, 3=STA, 4=BUN, 5=BSA, 6=ISZ, 7=extended. Bit 15 is the indirect flag and bits 11:0 are the address.
- R3: LDA loads AC with the operand word, and AND stores the bitwise AND of AC and the operand in AC. ADD stores the low 16 bits of the sum in AC and the carry-out in E. No other instruction except reset changes E.
- R4: STA writes AC to the effective address.
- R5: For opcodes 0 to 6, a set bit 15 makes the word at the address field the effective address (its low 12 bits). The instruction still takes the same number of slots.
- R6: BUN sets PC to the effective address. BSA writes the return address (PC after fetch) to the effective address and sets PC to the effective address plus 1. A later `BUN` indirect through that word returns.
- R7: ISZ writes the operand plus 1 back to memory. When the result is 0, it also advances PC by one more, which skips the next word.
- R8: An opcode 7 word with bit 15 clear is a register operation. Bit 11 clears AC, bit 9 complements AC, bit 5 increments AC and bit 0 sets the halt flag. When several bits are set, they apply in the order clear, complement, increment.
- R9: An opcode 7 word with bit 15 set is an I/O operation. It leaves AC, E and memory unchanged and completes.
- R10: Slots per instruction are 4 for extended operations, 5 for STA and BUN, 6 for AND, ADD, LDA and BSA, and 7 for ISZ. The next fetch follows with no idle slot, and the eighth slot is never reached.
- R11: Once the halt flag is set, PC, AC and E stay unchanged until reset, even with `run_i` high.
- R12: A preload write stores `pre_data_i` at `pre_addr_i` on the clock edge. `pk_data_o` shows the word at `pk_addr_i` without delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | Allows the sequencer to advance |
| pre_we_i | input | 1 | Preload write enable |
| pre_addr_i | input | 12 | Preload write address |
| pre_data_i | input | 16 | Preload write data |
| pk_addr_i | input | 12 | Memory peek address |
| pk_data_o | output | 16 | Memory word at the peek address |
| acc_o | output | 16 | Accumulator |
| pc_o | output | 12 | Program counter |
| carry_o | output | 1 | E (carry) flag |
| halted_o | output | 1 | Halt flag |

## Verification
The assertions assume that preload writes happen only while `run_i` is low. Otherwise a program write and a preload write could meet at the same memory port. The stimulus always preloads after a reset pulse and before `run_i` rises. The assertions also assume that each program ends in a halt word. Every directed program ends with an opcode 7 word whose bit 0 is set, and the bench lowers `run_i` again once the halt flag is seen. Memory is not cleared by reset, so each scenario writes every word that its program reaches.

// File: rtl/acc_pkg.sv
package acc_pkg;

    typedef enum logic [2:0] {
        OP_AND = 3'd0,
        OP_ADD = 3'd1,
        OP_LDA = 3'd2,
        OP_STA = 3'd3,
        OP_BUN = 3'd4,
        OP_BSA = 3'd5,
        OP_ISZ = 3'd6,
        OP_EXT = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        SRC_NONE = 3'd0,
        SRC_AR   = 3'd1,
        SRC_PC   = 3'd2,
        SRC_DR   = 3'd3,
        SRC_AC   = 3'd4,
        SRC_IR   = 3'd5,
        SRC_MEM  = 3'd7
    } bus_src_e;

    typedef enum logic [1:0] {
        ALU_PASS = 2'd0,
        ALU_AND  = 2'd1,
        ALU_ADD  = 2'd2
    } alu_op_e;

    // bit positions inside the address field for register operations
    localparam int RB_CLR  = 11;
    localparam int RB_CMP  = 9;
    localparam int RB_INC  = 5;
    localparam int RB_HALT = 0;

endpackage

// File: rtl/acc_timer.sv
module acc_timer #(
    parameter int SC_W = 3
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  adv_i,
    input  logic                  clr_i,
    output logic [(1<<SC_W)-1:0]  slot_o
);
    localparam int NSLOT = 1 << SC_W;

    logic [SC_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr_i)
            cnt_d = '0;
        else if (adv_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) cnt_q <= '0;
        else         cnt_q <= cnt_d;
    end

    generate
        for (genvar g = 0; g < NSLOT; g++) begin : g_dec
            assign slot_o[g] = (cnt_q == SC_W'(g));
        end
    endgenerate

    // R10
    restart_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> slot_o[0])
        else $error("slot counter did not restart");

    // R10
    slot_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (adv_i && !clr_i) |=> (cnt_q == $past(cnt_q) + 1'b1))
        else $error("slot counter did not advance");

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int WORD_W = 16
) (
    input  alu_op_e             op_i,
    input  logic [WORD_W-1:0]   a_i,
    input  logic [WORD_W-1:0]   b_i,
    output logic [WORD_W-1:0]   y_o,
    output logic                cy_o
);
    logic [WORD_W:0] sum;

    assign sum = {1'b0, a_i} + {1'b0, b_i};

    always_comb begin
        cy_o = 1'b0;
        unique case (op_i)
            ALU_AND: y_o = a_i & b_i;
            ALU_ADD: begin
                y_o  = sum[WORD_W-1:0];
                cy_o = sum[WORD_W];
            end
            default: y_o = b_i;
        endcase
    end

endmodule

// File: rtl/acc_mem.sv
module acc_mem #(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12
) (
    input  logic              clk_i,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [WORD_W-1:0] rdata_o,
    input  logic [ADDR_W-1:0] pk_addr_i,
    output logic [WORD_W-1:0] pk_data_o
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [WORD_W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk_i) begin
        if (we_i) cell_q[waddr_i] <= wdata_i;
    end

    assign rdata_o   = cell_q[raddr_i];
    assign pk_data_o = cell_q[pk_addr_i];

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
    import acc_pkg::*;
#(
    parameter int WORD_W = 16,
    parameter int ADDR_W = 12,
    parameter int SC_W   = 3
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              run_i,
    input  logic              pre_we_i,
    input  logic [ADDR_W-1:0] pre_addr_i,
    input  logic [WORD_W-1:0] pre_data_i,
    input  logic [ADDR_W-1:0] pk_addr_i,
    output logic [WORD_W-1:0] pk_data_o,
    output logic [WORD_W-1:0] acc_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              carry_o,
    output logic              halted_o
);
    localparam int NSLOT  = 1 << SC_W;
    localparam int OP_LSB = ADDR_W;
    localparam int IND_B  = WORD_W - 1;

    typedef struct packed {
        logic [ADDR_W-1:0] ar;
        logic [ADDR_W-1:0] pc;
        logic [WORD_W-1:0] dr;
        logic [WORD_W-1:0] ac;
        logic [WORD_W-1:0] ir;
        logic              e;
        logic              ind;
        logic              halt;
    } core_s;

    core_s r_d, r_q;

    logic [NSLOT-1:0]  slot;
    logic [7:0]        dop;
    logic              step, last, is_ext;
    bus_src_e          bus_sel;
    logic [WORD_W-1:0] bus, mem_rdata, acc_t;
    logic              core_we, mem_we;
    logic [ADDR_W-1:0] mem_waddr;
    logic [WORD_W-1:0] mem_wdata;
    alu_op_e           alu_op;
    logic [WORD_W-1:0] alu_y;
    logic              alu_cy;

    assign step   = run_i && !r_q.halt;
    assign dop    = 8'b1 << r_q.ir[OP_LSB+2:OP_LSB];
    assign is_ext = dop[OP_EXT];

    acc_timer #(.SC_W(SC_W)) u_timer (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .adv_i  (step),
        .clr_i  (step && last),
        .slot_o (slot)
    );

    // bus source selection per slot
    always_comb begin
        bus_sel = SRC_NONE;
        if (slot[0]) bus_sel = SRC_PC;
        if (slot[1]) bus_sel = SRC_MEM;
        if (slot[2]) bus_sel = SRC_IR;
        if (slot[3] && !is_ext && r_q.ind) bus_sel = SRC_MEM;
        if (slot[4]) begin
            if (dop[OP_AND] || dop[OP_ADD] || dop[OP_LDA] || dop[OP_ISZ])
                bus_sel = SRC_MEM;
            if (dop[OP_STA]) bus_sel = SRC_AC;
            if (dop[OP_BUN]) bus_sel = SRC_AR;
            if (dop[OP_BSA]) bus_sel = SRC_PC;
        end
        if (slot[5]) begin
            if (dop[OP_AND] || dop[OP_ADD] || dop[OP_LDA]) bus_sel = SRC_DR;
            if (dop[OP_BSA]) bus_sel = SRC_AR;
        end
        if (slot[6] && dop[OP_ISZ]) bus_sel = SRC_DR;
    end

    always_comb begin
        unique case (bus_sel)
            SRC_AR:  bus = WORD_W'(r_q.ar);
            SRC_PC:  bus = WORD_W'(r_q.pc);
            SRC_DR:  bus = r_q.dr;
            SRC_AC:  bus = r_q.ac;
            SRC_IR:  bus = r_q.ir;
            SRC_MEM: bus = mem_rdata;
            default: bus = '0;
        endcase
    end

    always_comb begin
        alu_op = ALU_PASS;
        if (dop[OP_AND]) alu_op = ALU_AND;
        if (dop[OP_ADD]) alu_op = ALU_ADD;
    end

    acc_alu #(.WORD_W(WORD_W)) u_alu (
        .op_i (alu_op),
        .a_i  (r_q.ac),
        .b_i  (bus),
        .y_o  (alu_y),
        .cy_o (alu_cy)
    );

    // memory write from the bus, preload port wins
    assign core_we   = step && ((slot[4] && (dop[OP_STA] || dop[OP_BSA]))
                              || (slot[6] && dop[OP_ISZ]));
    assign mem_we    = core_we || pre_we_i;
    assign mem_waddr = pre_we_i ? pre_addr_i : r_q.ar;
    assign mem_wdata = pre_we_i ? pre_data_i : bus;

    acc_mem #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_mem (
        .clk_i     (clk_i),
        .we_i      (mem_we),
        .waddr_i   (mem_waddr),
        .wdata_i   (mem_wdata),
        .raddr_i   (r_q.ar),
        .rdata_o   (mem_rdata),
        .pk_addr_i (pk_addr_i),
        .pk_data_o (pk_data_o)
    );

    // next-state computation
    always_comb begin
        r_d   = r_q;
        last  = 1'b0;
        acc_t = r_q.ac;
        if (step) begin
            if (slot[0]) r_d.ar = bus[ADDR_W-1:0];
            if (slot[1]) begin
                r_d.ir = bus;
                r_d.pc = r_q.pc + 1'b1;
            end
            if (slot[2]) begin
                r_d.ar  = bus[ADDR_W-1:0];
                r_d.ind = r_q.ir[IND_B];
            end
            if (slot[3]) begin
                if (is_ext) begin
                    last = 1'b1;
                    if (!r_q.ind) begin
                        if (r_q.ir[RB_CLR]) acc_t = '0;
                        if (r_q.ir[RB_CMP]) acc_t = ~acc_t;
                        if (r_q.ir[RB_INC]) acc_t = acc_t + 1'b1;
                        r_d.ac = acc_t;
                        if (r_q.ir[RB_HALT]) r_d.halt = 1'b1;
                    end
                end else if (r_q.ind) begin
                    r_d.ar = bus[ADDR_W-1:0];
                end
            end
            if (slot[4]) begin
                if (dop[OP_AND] || dop[OP_ADD] || dop[OP_LDA] || dop[OP_ISZ])
                    r_d.dr = bus;
                if (dop[OP_STA]) last = 1'b1;
                if (dop[OP_BUN]) begin
                    r_d.pc = bus[ADDR_W-1:0];
                    last   = 1'b1;
                end
                if (dop[OP_BSA]) r_d.ar = r_q.ar + 1'b1;
            end
            if (slot[5]) begin
                if (dop[OP_AND] || dop[OP_ADD] || dop[OP_LDA]) begin
                    r_d.ac = alu_y;
                    if (dop[OP_ADD]) r_d.e = alu_cy;
                    last = 1'b1;
                end
                if (dop[OP_BSA]) begin
                    r_d.pc = bus[ADDR_W-1:0];
                    last   = 1'b1;
                end
                if (dop[OP_ISZ]) r_d.dr = r_q.dr + 1'b1;
            end
            if (slot[6] && dop[OP_ISZ]) begin
                if (r_q.dr == '0) r_d.pc = r_q.pc + 1'b1;
                last = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) r_q <= '0;
        else         r_q <= r_d;
    end

    assign acc_o    = r_q.ac;
    assign pc_o     = r_q.pc;
    assign carry_o  = r_q.e;
    assign halted_o = r_q.halt;

    // R2
    fetch_pc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && slot[1]) |=> (r_q.pc == $past(r_q.pc) + 1'b1))
        else $error("PC did not advance during fetch");

    // R3
    carry_only_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(step && slot[5] && dop[OP_ADD]) |=> $stable(r_q.e))
        else $error("E changed outside ADD");

    // R6
    bsa_link_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (step && slot[4] && dop[OP_BSA]) |-> (core_we && mem_wdata == WORD_W'(r_q.pc)))
        else $error("BSA did not store return address");

    // R10
    no_last_slot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step |-> !slot[NSLOT-1])
        else $error("sequencer reached final slot");

    // R11
    halt_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        r_q.halt |=> (r_q.halt && $stable(r_q.pc) && $stable(r_q.ac) && $stable(r_q.e)))
        else $error("state moved while halted");

endmodule

// File: tb/sim_acc_cpu_core.sv
module sim_acc_cpu_core;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic        pre_we = 1'b0;
    logic [11:0] pre_addr = '0;
    logic [15:0] pre_data = '0;
    logic [11:0] pk_addr = '0;
    logic [15:0] pk_data, acc;
    logic [11:0] pc;
    logic        carry, halted;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    acc_cpu_core u0 (
        .clk_i(clk), .rst_ni(rst_n), .run_i(run),
        .pre_we_i(pre_we), .pre_addr_i(pre_addr), .pre_data_i(pre_data),
        .pk_addr_i(pk_addr), .pk_data_o(pk_data),
        .acc_o(acc), .pc_o(pc), .carry_o(carry), .halted_o(halted)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic restart();
        run = 1'b0;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic put(input logic [11:0] a, input logic [15:0] d);
        pre_we = 1'b1; pre_addr = a; pre_data = d;
        @(negedge clk);
        pre_we = 1'b0;
    endtask

    task automatic peek(input logic [11:0] a, output logic [15:0] d);
        pk_addr = a;
        #1;
        d = pk_data;
    endtask

    task automatic go(output int cyc);
        cyc = 0;
        run = 1'b1;
        while (!halted && cyc < 400) begin
            @(negedge clk);
            cyc++;
        end
        run = 1'b0;
    endtask

    task automatic t_reset();
        restart();
        check("R1 pc", 32'(pc), 32'h0);
        check("R1 acc", 32'(acc), 32'h0);
        check("R1 carry", 32'(carry), 32'h0);
        check("R1 halted", 32'(halted), 32'h0);
        put(12'd0, 16'h7001);
        repeat (10) @(negedge clk);
        check("R1 idle pc", 32'(pc), 32'h0);
    endtask

    task automatic t_load_add_store();
        int c; logic [15:0] m;
        restart();
        put(12'd0, 16'h2064); put(12'd1, 16'h1065); put(12'd2, 16'h3066); put(12'd3, 16'h7001);
        put(12'd100, 16'd5); put(12'd101, 16'd7); put(12'd102, 16'd0);
        go(c);
        check("R3 add acc", 32'(acc), 32'd12);
        check("R3 no carry", 32'(carry), 32'h0);
        peek(12'd102, m);
        check("R4 store", 32'(m), 32'd12);
        check("R2 pc", 32'(pc), 32'd4);
        check("R10 cycles lda add sta hlt", 32'(c), 32'd21);
    endtask

    task automatic t_carry_and();
        int c;
        restart();
        put(12'd0, 16'h203C); put(12'd1, 16'h103D); put(12'd2, 16'h7001);
        put(12'd60, 16'hFFFF); put(12'd61, 16'h0002);
        go(c);
        check("R3 carry acc", 32'(acc), 32'h1);
        check("R3 carry e", 32'(carry), 32'h1);
        restart();
        put(12'd0, 16'h203C); put(12'd1, 16'h003D); put(12'd2, 16'h7001);
        put(12'd60, 16'hF0F0); put(12'd61, 16'h0FF0);
        go(c);
        check("R3 and", 32'(acc), 32'h00F0);
    endtask

    task automatic t_indirect();
        int c;
        restart();
        put(12'd0, 16'hA0C8); put(12'd1, 16'h7001);
        put(12'd200, 16'h0123); put(12'h123, 16'hBEEF);
        go(c);
        check("R5 indirect load", 32'(acc), 32'hBEEF);
        check("R5 indirect cycles", 32'(c), 32'd10);
    endtask

    task automatic t_branch();
        int c; logic [15:0] m;
        restart();
        put(12'd0, 16'h400A); put(12'd1, 16'h7001); put(12'd10, 16'h7001);
        go(c);
        check("R6 bun pc", 32'(pc), 32'd11);
        check("R10 bun hlt cycles", 32'(c), 32'd9);
        restart();
        put(12'd0, 16'h5014); put(12'd1, 16'h7001);
        put(12'd20, 16'h0000); put(12'd21, 16'hC014);
        go(c);
        peek(12'd20, m);
        check("R6 bsa link", 32'(m), 32'd1);
        check("R6 return pc", 32'(pc), 32'd2);
        check("R10 bsa bun hlt cycles", 32'(c), 32'd15);
    endtask

    task automatic t_isz();
        int c; logic [15:0] m;
        restart();
        put(12'd0, 16'h6032); put(12'd1, 16'h7001); put(12'd2, 16'h7001);
        put(12'd50, 16'hFFFF);
        go(c);
        peek(12'd50, m);
        check("R7 isz wrap", 32'(m), 32'h0);
        check("R7 isz skip pc", 32'(pc), 32'd3);
        check("R10 isz hlt cycles", 32'(c), 32'd11);
        restart();
        put(12'd50, 16'd5);
        go(c);
        peek(12'd50, m);
        check("R7 isz incr", 32'(m), 32'd6);
        check("R7 isz no skip pc", 32'(pc), 32'd2);
    endtask

    task automatic t_register_ops();
        int c;
        restart();
        put(12'd0, 16'h203C); put(12'd1, 16'h7200); put(12'd2, 16'h7020);
        put(12'd3, 16'h103D); put(12'd4, 16'h7001);
        put(12'd60, 16'd4); put(12'd61, 16'd9);
        go(c);
        check("R8 subtract acc", 32'(acc), 32'd5);
        check("R8 subtract carry", 32'(carry), 32'h1);
        restart();
        put(12'd0, 16'h203C); put(12'd1, 16'h7A00); put(12'd2, 16'h7001);
        put(12'd60, 16'h1234);
        go(c);
        check("R8 clear then complement", 32'(acc), 32'hFFFF);
    endtask

    task automatic t_io_and_halt();
        int c; logic [11:0] p; logic [15:0] a;
        restart();
        put(12'd0, 16'h203C); put(12'd1, 16'hF821); put(12'd2, 16'h7001);
        put(12'd60, 16'h1234);
        go(c);
        check("R9 io acc kept", 32'(acc), 32'h1234);
        check("R9 io pc", 32'(pc), 32'd3);
        check("R10 io cycles", 32'(c), 32'd14);
        check("R11 halted", 32'(halted), 32'h1);
        p = pc; a = acc;
        run = 1'b1;
        repeat (20) @(negedge clk);
        run = 1'b0;
        check("R11 pc hold", 32'(pc), 32'(p));
        check("R11 acc hold", 32'(acc), 32'(a));
    endtask

    task automatic t_preload();
        logic [15:0] m;
        restart();
        put(12'hFFF, 16'hA5C3);
        peek(12'hFFF, m);
        check("R12 preload top word", 32'(m), 32'hA5C3);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        t_reset();
        t_load_add_store();
        t_carry_and();
        t_indirect();
        t_branch();
        t_isz();
        t_register_ops();
        t_io_and_halt();
        t_preload();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule